// File: doc/BRIEF.md
# Base-and-Limit Address Relocator

This block sits on the address path between a processor and memory. Each logical address that a user process issues is checked against a limit value. While that check runs, a base offset is added to the same address in the same stage. An address that passes goes to memory as a physical address. An address that fails produces no memory access. Instead it raises an addressing-error trap and records the offending logical address.

Privileged software loads the base and limit values through a one-word register-write port. A supervisor input turns off both the check and the offset, so the kernel reaches physical memory directly. Requests move under a valid/ready handshake. The output stage holds its address while memory stalls, and it takes no new request during the stall.

Top module: `addr_relocator`

## Requirements
- R1: While and after synchronous reset, `mem_valid` is 0, `trap` is 0 and `fault_addr` is 0. Base and limit both reset to 0, so every user request traps until the limit is loaded.
- R2: A user request (`req_super`=0) with address strictly below the limit gives `mem_valid`=1 one cycle after acceptance. `mem_addr` equals base plus the zero-extended address, modulo 2^PA_W.
- R3: A user request with address greater than or equal to the limit gives `trap`=1 one cycle after acceptance, with `mem_valid`=0 in that cycle.
- R4: `fault_addr` takes the logical address of a trapping request in the same cycle that `trap` rises. It keeps that value until the next trap.
- R5: A supervisor request (`req_super`=1) never traps. It gives `mem_valid`=1 with `mem_addr` equal to the zero-extended logical address, whatever the base and limit values are.
- R6: When `cfg_we`=1 and `cfg_sel`=0, `cfg_wdata` is written to base. When `cfg_we`=1 and `cfg_sel`=1, `cfg_wdata` is written to limit. A request accepted in the same cycle as the write uses the old values. A request accepted in any later cycle uses the new values.
- R7: While `mem_valid`=1 and `mem_ready`=0, `req_ready` is 0, and `mem_valid` and `mem_addr` hold unchanged into the next cycle.
- R8: `trap` is a one-cycle pulse for each trapping request. It is never 1 in a cycle that follows a cycle with no accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Write target: 0 = base, 1 = limit |
| cfg_wdata | input | PA_W | Register write value |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_addr | input | LA_W | Logical address |
| req_super | input | 1 | Supervisor mode: bypass check and offset |
| mem_valid | output | 1 | Physical access valid |
| mem_ready | input | 1 | Memory takes the access |
| mem_addr | output | PA_W | Physical address |
| trap | output | 1 | Addressing-error pulse |
| fault_addr | output | LA_W | Last faulting logical address |

## Verification
The assertions assume that memory follows the handshake. It may hold `mem_ready` low for any number of cycles, and a request counts as taken only in a cycle where both valid and ready are high. They also assume that the inputs are stable around the clock edge. The bench changes every input only at the falling edge. It drops `req_valid` after each accepted request. Stalls come only from `mem_ready`, which it raises again before the next request. Configuration writes stay within PA_W, and the limit stays at or below 2^LA_W, so the boundary cases fall at addresses the bench can issue.

// File: rtl/rg_pkg.sv
package rg_pkg;
  typedef enum logic {
    CFG_BASE  = 1'b0,
    CFG_LIMIT = 1'b1
  } cfg_sel_e;
endpackage

// File: rtl/rg_cfg_regs.sv
module rg_cfg_regs #(
  parameter int PA_W = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cfg_we,
  input  rg_pkg::cfg_sel_e      cfg_sel,
  input  logic [PA_W-1:0]       cfg_wdata,
  output logic [PA_W-1:0]       base_q,
  output logic [PA_W-1:0]       limit_q
);
  // R6: a write lands at the clock edge, so only later requests see it
  always_ff @(posedge clk) begin
    if (rst) begin
      base_q  <= '0;
      limit_q <= '0;
    end else if (cfg_we) begin
      if (cfg_sel == rg_pkg::CFG_BASE) base_q  <= cfg_wdata;
      else                             limit_q <= cfg_wdata;
    end
  end
endmodule

// File: rtl/rg_xlate_stage.sv
module rg_xlate_stage #(
  parameter int LA_W = 12,
  parameter int PA_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PA_W-1:0] base_q,
  input  logic [PA_W-1:0] limit_q,
  input  logic            req_valid,
  input  logic [LA_W-1:0] req_addr,
  input  logic            req_super,
  output logic            req_ready,
  input  logic            mem_ready,
  output logic            mem_valid,
  output logic [PA_W-1:0] mem_addr,
  output logic            trap,
  output logic [LA_W-1:0] fault_addr
);
  localparam int EXT_W = PA_W - LA_W;

  logic [PA_W-1:0] addr_ext;
  logic [PA_W-1:0] reloc_addr;
  logic            in_range;
  logic            accept;

  generate
    if (EXT_W > 0) begin : g_ext
      assign addr_ext = {{EXT_W{1'b0}}, req_addr};
    end else begin : g_same
      assign addr_ext = req_addr[PA_W-1:0];
    end
  endgenerate

  // limit compare and base add run side by side in one stage
  assign in_range   = addr_ext < limit_q;
  assign reloc_addr = base_q + addr_ext;
  assign req_ready  = !mem_valid || mem_ready;
  assign accept     = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_valid  <= 1'b0;
      mem_addr   <= '0;
      trap       <= 1'b0;
      fault_addr <= '0;
    end else begin
      trap <= 1'b0;
      if (accept) begin
        if (req_super) begin
          mem_valid <= 1'b1;
          mem_addr  <= addr_ext;
        end else if (in_range) begin
          mem_valid <= 1'b1;
          mem_addr  <= reloc_addr;
        end else begin
          mem_valid  <= 1'b0;
          trap       <= 1'b1;
          fault_addr <= req_addr;
        end
      end else if (mem_ready) begin
        mem_valid <= 1'b0;
      end
    end
  end

  assert_trap_no_access_R3: assert property (@(posedge clk) disable iff (rst)
    trap |-> !mem_valid);

  assert_fault_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !trap |-> $stable(fault_addr));

  assert_super_no_trap_R5: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_super) |=> !trap);

  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)));

  assert_trap_cause_R8: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && req_ready) |=> !trap);
endmodule

// File: rtl/addr_relocator.sv
module addr_relocator #(
  parameter int LA_W = 12,
  parameter int PA_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_we,
  input  logic            cfg_sel,
  input  logic [PA_W-1:0] cfg_wdata,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [LA_W-1:0] req_addr,
  input  logic            req_super,
  output logic            mem_valid,
  input  logic            mem_ready,
  output logic [PA_W-1:0] mem_addr,
  output logic            trap,
  output logic [LA_W-1:0] fault_addr
);
  logic [PA_W-1:0] base_q;
  logic [PA_W-1:0] limit_q;

  rg_cfg_regs #(.PA_W(PA_W)) i_regs (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_sel   (rg_pkg::cfg_sel_e'(cfg_sel)),
    .cfg_wdata (cfg_wdata),
    .base_q    (base_q),
    .limit_q   (limit_q)
  );

  rg_xlate_stage #(.LA_W(LA_W), .PA_W(PA_W)) i_xlate (
    .clk        (clk),
    .rst        (rst),
    .base_q     (base_q),
    .limit_q    (limit_q),
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .req_super  (req_super),
    .req_ready  (req_ready),
    .mem_ready  (mem_ready),
    .mem_valid  (mem_valid),
    .mem_addr   (mem_addr),
    .trap       (trap),
    .fault_addr (fault_addr)
  );

  initial begin
    assert (PA_W > LA_W) else $error("PA_W must exceed LA_W");
  end
endmodule

// File: tb/test_addr_relocator.sv
module test_addr_relocator;
  localparam int LA_W = 12;
  localparam int PA_W = 16;
  localparam time CLK_PERIOD = 10ns;
  localparam int NVEC = 8;
  // {super, addr[11:0], exp_trap, exp_addr[15:0]} with base=0x3400 limit=0x0800
  localparam logic [29:0] VEC [NVEC] = '{
    {1'b0, 12'h000, 1'b0, 16'h3400},
    {1'b0, 12'h7FF, 1'b0, 16'h3BFF},
    {1'b0, 12'h800, 1'b1, 16'h0000},
    {1'b0, 12'hFFF, 1'b1, 16'h0000},
    {1'b1, 12'hFFF, 1'b0, 16'h0FFF},
    {1'b0, 12'h123, 1'b0, 16'h3523},
    {1'b1, 12'h000, 1'b0, 16'h0000},
    {1'b0, 12'h801, 1'b1, 16'h0000}
  };

  logic clk = 0, rst = 1;
  logic cfg_we = 0, cfg_sel = 0;
  logic [PA_W-1:0] cfg_wdata = '0;
  logic req_valid = 0, req_super = 0, mem_ready = 1;
  logic [LA_W-1:0] req_addr = '0;
  logic req_ready, mem_valid, trap;
  logic [PA_W-1:0] mem_addr;
  logic [LA_W-1:0] fault_addr;
  int n_tests = 0, n_fail = 0, cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  addr_relocator #(.LA_W(LA_W), .PA_W(PA_W)) i_addr_relocator (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_super(req_super), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_addr(mem_addr), .trap(trap), .fault_addr(fault_addr));

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic sel, input logic [PA_W-1:0] val);
    @(negedge clk);
    cfg_we = 1; cfg_sel = sel; cfg_wdata = val;
    @(negedge clk);
    cfg_we = 0;
  endtask

  // issue one request with mem_ready high; sample outputs at the next falling edge
  task automatic issue(input logic sup, input logic [LA_W-1:0] a);
    @(negedge clk);
    req_valid = 1; req_super = sup; req_addr = a;
    @(negedge clk);
    req_valid = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 mem_valid in reset", 32'(mem_valid), 0);
    check("R1 trap in reset", 32'(trap), 0);
    rst = 0;
    @(negedge clk);
    check("R1 fault_addr after reset", 32'(fault_addr), 0);
    check("R1 mem_valid after reset", 32'(mem_valid), 0);

    // R1: limit resets to 0, so a user access traps
    issue(0, 12'h000);
    check("R1 zero limit traps", 32'(trap), 1);

    cfg_write(0, 16'h3400);
    cfg_write(1, 16'h0800);

    for (int i = 0; i < NVEC; i++) begin
      issue(VEC[i][29], VEC[i][28:17]);
      if (VEC[i][16]) begin
        check("R3 trap", 32'(trap), 1);
        check("R3 no access on trap", 32'(mem_valid), 0);
        check("R4 fault_addr", 32'(fault_addr), 32'(VEC[i][28:17]));
      end else begin
        check(VEC[i][29] ? "R5 super bypass valid" : "R2 valid", 32'(mem_valid), 1);
        check(VEC[i][29] ? "R5 super bypass addr" : "R2 relocated addr",
              32'(mem_addr), 32'(VEC[i][15:0]));
        check(VEC[i][29] ? "R5 no trap" : "R2 no trap", 32'(trap), 0);
      end
    end

    // R4: fault address held across a good access; R8: trap a single pulse
    issue(0, 12'h010);
    check("R4 fault_addr held", 32'(fault_addr), 32'h801);
    check("R8 trap low after good access", 32'(trap), 0);
    issue(0, 12'hA00);
    @(negedge clk);
    check("R8 trap one cycle", 32'(trap), 0);
    check("R4 fault_addr new", 32'(fault_addr), 32'hA00);

    // R6: write and request in the same cycle -> old limit applies
    @(negedge clk);
    cfg_we = 1; cfg_sel = 1; cfg_wdata = 16'h0100;
    req_valid = 1; req_super = 0; req_addr = 12'h200;
    @(negedge clk);
    cfg_we = 0; req_valid = 0;
    check("R6 old limit same cycle", 32'(trap), 0);
    check("R6 old limit addr", 32'(mem_addr), 32'h3600);
    issue(0, 12'h200);
    check("R6 new limit applies", 32'(trap), 1);
    issue(0, 12'h0FF);
    check("R6 below new limit", 32'(mem_addr), 32'h34FF);

    // R2: relocation wraps modulo 2^PA_W
    cfg_write(0, 16'hFFF0);
    issue(0, 12'h020);
    check("R2 wrap addr", 32'(mem_addr), 32'h0010);

    // R7: stall holds the output and blocks new requests
    @(negedge clk);
    mem_ready = 0; req_valid = 1; req_super = 0; req_addr = 12'h005;
    @(negedge clk);
    req_valid = 0;
    check("R7 valid under stall", 32'(mem_valid), 1);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R7 held valid", 32'(mem_valid), 1);
      check("R7 held addr", 32'(mem_addr), 32'hFFF5);
      check("R7 not ready", 32'(req_ready), 0);
    end
    // R7: a trapping request presented during the stall is not taken
    req_valid = 1; req_addr = 12'hFFF;
    @(negedge clk);
    check("R7 stalled request ignored", 32'(trap), 0);
    req_valid = 0;
    mem_ready = 1;
    @(negedge clk);
    check("R7 drains after ready", 32'(mem_valid), 0);

    // R8: idle cycles raise no trap
    repeat (2) @(negedge clk);
    check("R8 idle no trap", 32'(trap), 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule